// File: doc/BRIEF.md
# Three-Source Vectored Interrupt Controller

This block is the interrupt front end of a small 4-bit processor core. It watches three request sources: an external input pin, an underflow strobe from timer 1 and an underflow strobe from timer 2. Each request is captured in a sticky flag. A flag turns into an interrupt only when the source's enable bit and the global interrupt enable are both set. The block then offers a fixed vector to the program counter logic. The vectors sit at addresses 0, 4 and 6 of page 1.

When a source's enable bit is clear, the source is not ignored. The core can poll it instead through a skip-test query. The query returns the flag and clears it when it was set.

The vector output is a valid/ready stream. `vec_valid_o` is high whenever the global enable is set and at least one enabled flag is set. The core accepts in any cycle where valid and ready are both high. Acceptance clears the granted flag and the global enable. While valid waits for ready, the request stays pending. The address may move to a higher-priority source that arrives in the meantime. Valid can drop without acceptance only through `gie_clr_i` or a write that disables the source.

Top module: `irq3_ctrl`

## Requirements
- R1: After reset all three request flags, the enable register, the edge register and the global enable are clear. `vec_valid_o` and `skt_hit_o` are 0.
- R2: The pin passes through two synchronizing flip-flops. Edge-register bit 2 = 0 selects a falling edge and 1 selects a rising edge. A valid edge on the pin, set up before clock edge k, sets the external flag at clock edge k+2.
- R3: A one-cycle high on a timer underflow input sets that timer's flag at the next clock edge.
- R4: A source is pending when its flag and its enable bit are both 1. The enable bits are bit 0 for the external source, bit 2 for timer 1 and bit 3 for timer 2; bit 1 has no effect. `vec_valid_o` is 1 exactly when the global enable is 1 and some source is pending.
- R5: Among pending sources, the external source wins over timer 1, and timer 1 wins over timer 2.
- R6: `vec_addr_o` is 0 for the external source, 4 for timer 1 and 6 for timer 2. `vec_page_o` is 1.
- R7: Acceptance (valid and ready both 1) clears the granted flag and the global enable at that edge. Any clear of the global enable (acceptance or `gie_clr_i`) wins over `gie_set_i`.
- R8: While valid is high and ready is low, valid stays high in the next cycle, unless `gie_clr_i` or an enable write occurs.
- R9: Skip-test selects are 0 for the external source, 1 for timer 1 and 2 for timer 2; select 3 never hits. `skt_hit_o` equals the selected flag only when that source's enable bit is 0, and a hit clears the flag. When the source is enabled, the hit is 0 and the flag is unchanged.
- R10: A new request arriving in the same cycle as a clear of that flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | External request pin, asynchronous |
| t1_uflow_i | input | 1 | Timer 1 underflow strobe |
| t2_uflow_i | input | 1 | Timer 2 underflow strobe |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 4 | Enable register write data |
| edge_we_i | input | 1 | Write strobe for the edge register |
| edge_wdata_i | input | 4 | Edge register write data (bit 2 = polarity) |
| gie_set_i | input | 1 | Set the global interrupt enable |
| gie_clr_i | input | 1 | Clear the global interrupt enable |
| vec_valid_o | output | 1 | Vector offered |
| vec_ready_i | input | 1 | Core takes the vector |
| vec_addr_o | output | 7 | Vector address within the page |
| vec_page_o | output | 4 | Vector page number |
| skt_req_i | input | 1 | Skip-test query |
| skt_sel_i | input | 2 | Source selected by the query |
| skt_hit_o | output | 1 | Query result, combinational |

## Verification
The assertions assume that the timer strobes are synchronous to `clk` and that the core does not rewrite the enable register in a cycle where it relies on valid being held. The pin is the only asynchronous input. The bench keeps the pin low through reset, so no false edge appears on release. It changes all inputs only at the falling clock edge, keeping every input synchronous apart from the deliberately unsynchronized pin. Enable writes are made rare, so that the hold property covers long stretches of back-pressure.

// File: rtl/irq3_pkg.sv
package irq3_pkg;
  localparam int NSRC = 3;
  localparam int ADDR_W = 7;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_T1   = 2'd1,
    SRC_T2   = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  // Fixed vector address for each source inside the vector page.
  function automatic logic [ADDR_W-1:0] vec_of(input src_e s);
    case (s)
      SRC_EXT: vec_of = ADDR_W'(0);
      SRC_T1:  vec_of = ADDR_W'(4);
      SRC_T2:  vec_of = ADDR_W'(6);
      default: vec_of = ADDR_W'(0);
    endcase
  endfunction

  // Maps a source index to its bit in the enable register.
  function automatic logic en_bit(input logic [3:0] en, input logic [1:0] idx);
    case (idx)
      2'd0:    en_bit = en[0];
      2'd1:    en_bit = en[2];
      2'd2:    en_bit = en[3];
      default: en_bit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/irq3_pin_edge.sv
module irq3_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_o
);
  logic [STAGES:0] sh_q;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_sh
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[0] <= 1'b0;
          else        sh_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  // Newest synchronized sample against the one before it.
  assign edge_o = rise_sel ? (sh_q[STAGES-1] & ~sh_q[STAGES])
                           : (~sh_q[STAGES-1] & sh_q[STAGES]);

  // An edge lasts one cycle: the delayed sample catches up.
  a_r2_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && !$changed(rise_sel)) |=> !(edge_o && $stable(rise_sel)));
endmodule

// File: rtl/irq3_flags.sv
module irq3_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] fl_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_fl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q[g] <= 1'b0;
        else        fl_q[g] <= (fl_q[g] & ~clr_i[g]) | set_i[g];
      end

      // R10: a new request is never lost to a simultaneous clear.
      a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[g] |=> fl_q[g]);
      // R9/R7: a clear without a new request empties the flag.
      a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[g] && !set_i[g]) |=> !fl_q[g]);
    end
  endgenerate

  assign flag_o = fl_q;
endmodule

// File: rtl/irq3_arb.sv
module irq3_arb
  import irq3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   pend_i,
  output logic [NSRC-1:0]   grant_o,
  output logic [ADDR_W-1:0] addr_o
);
  src_e win;

  // Lowest index wins: external, then timer 1, then timer 2.
  always_comb begin
    win     = SRC_NONE;
    grant_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        win     = src_e'(i);
        grant_o = '0;
        grant_o[i] = 1'b1;
      end
    end
    addr_o = vec_of(win);
  end

  a_r5_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_i) |-> ($onehot(grant_o) && ((grant_o & pend_i) == grant_o)));
  a_r5_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
    pend_i[0] |-> (addr_o == ADDR_W'(0)));
endmodule

// File: rtl/irq3_ctrl.sv
module irq3_ctrl
  import irq3_pkg::*;
#(
  parameter int PAGE_W   = 4,
  parameter int VEC_PAGE = 1,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              t1_uflow_i,
  input  logic              t2_uflow_i,
  input  logic              en_we_i,
  input  logic [3:0]        en_wdata_i,
  input  logic              edge_we_i,
  input  logic [3:0]        edge_wdata_i,
  input  logic              gie_set_i,
  input  logic              gie_clr_i,
  output logic              vec_valid_o,
  input  logic              vec_ready_i,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [PAGE_W-1:0] vec_page_o,
  input  logic              skt_req_i,
  input  logic [1:0]        skt_sel_i,
  output logic              skt_hit_o
);
  localparam int POL_BIT = 2;

  logic [3:0]      en_q, edg_q;
  logic            gie_q;
  logic            pin_edge;
  logic [NSRC-1:0] flags, pend, grant, set_v, clr_v, skt_clr, src_en;
  logic            accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      edg_q <= '0;
    end else begin
      if (en_we_i)   en_q  <= en_wdata_i;
      if (edge_we_i) edg_q <= edge_wdata_i;
    end
  end

  irq3_pin_edge #(.STAGES(SYNC_N)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (pin_i),
    .rise_sel (edg_q[POL_BIT]),
    .edge_o   (pin_edge)
  );

  assign set_v = {t2_uflow_i, t1_uflow_i, pin_edge};

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      assign src_en[g]  = en_bit(en_q, 2'(g));
      assign pend[g]    = flags[g] & src_en[g];
      assign skt_clr[g] = skt_req_i && (skt_sel_i == 2'(g)) && !src_en[g] && flags[g];
    end
  endgenerate

  irq3_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (pend),
    .grant_o (grant),
    .addr_o  (vec_addr_o)
  );

  assign vec_valid_o = gie_q & (|pend);
  assign vec_page_o  = PAGE_W'(VEC_PAGE);
  assign accept      = vec_valid_o & vec_ready_i;
  assign clr_v       = skt_clr | (accept ? grant : '0);
  assign skt_hit_o   = |skt_clr;

  irq3_flags #(.N(NSRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .flag_o (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   gie_q <= 1'b0;
    else if (accept || gie_clr_i) gie_q <= 1'b0;
    else if (gie_set_i)           gie_q <= 1'b1;
  end

  a_r4_valid_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> gie_q);
  a_r7_accept_drops_gie: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !gie_q);
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_ready_i && !gie_clr_i && !en_we_i) |=> vec_valid_o);
  a_r9_no_hit_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (skt_req_i && en_bit(en_q, skt_sel_i)) |-> !skt_hit_o);
endmodule

// File: tb/irq3_ctrl_tb.sv
module irq3_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC = 4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin, t1, t2, en_we, edge_we, gie_set, gie_clr, ready, skt_req;
  logic [3:0] en_wd, edge_wd;
  logic [1:0] skt_sel;
  logic vvalid, hit;
  logic [6:0] vaddr;
  logic [3:0] vpage;

  int checks = 0, errors = 0;
  bit done = 0;

  // Bench model state.
  logic m_s1, m_s2, m_s3, m_gie;
  logic [2:0] m_fl;
  logic [3:0] m_en, m_edg;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq3_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .t1_uflow_i(t1), .t2_uflow_i(t2),
    .en_we_i(en_we), .en_wdata_i(en_wd), .edge_we_i(edge_we), .edge_wdata_i(edge_wd),
    .gie_set_i(gie_set), .gie_clr_i(gie_clr), .vec_valid_o(vvalid),
    .vec_ready_i(ready), .vec_addr_o(vaddr), .vec_page_o(vpage),
    .skt_req_i(skt_req), .skt_sel_i(skt_sel), .skt_hit_o(hit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic f_en(input logic [3:0] en, input int i);
    return (i == 0) ? en[0] : (i == 1) ? en[2] : (i == 2) ? en[3] : 1'b0;
  endfunction

  function automatic logic [2:0] f_pend();
    logic [2:0] p;
    for (int i = 0; i < 3; i++) p[i] = m_fl[i] & f_en(m_en, i);
    return p;
  endfunction

  function automatic int f_win(input logic [2:0] p);
    if (p[0]) return 0;
    if (p[1]) return 1;
    if (p[2]) return 2;
    return 3;
  endfunction

  function automatic logic [6:0] f_addr(input int w);
    return (w == 1) ? 7'd4 : (w == 2) ? 7'd6 : 7'd0;
  endfunction

  function automatic logic f_hit();
    int s = int'(skt_sel);
    if (!skt_req || s == 3) return 1'b0;
    return !f_en(m_en, s) & m_fl[s];
  endfunction

  task automatic idle();
    pin = 0; t1 = 0; t2 = 0; en_we = 0; edge_we = 0; en_wd = 0; edge_wd = 0;
    gie_set = 0; gie_clr = 0; ready = 0; skt_req = 0; skt_sel = 0;
  endtask

  task automatic check_outputs();
    logic [2:0] p = f_pend();
    logic ev = m_gie & (|p);
    chk("R4 valid", vvalid, ev);
    if (ev) chk("R5/R6 addr", vaddr, f_addr(f_win(p)));
    chk("R6 page", vpage, 4'd1);
    chk("R9 skip hit", hit, f_hit());
  endtask

  task automatic model_step();
    logic [2:0] p = f_pend();
    logic acc = m_gie & (|p) & ready;
    logic edg = m_edg[2] ? (m_s2 & ~m_s3) : (~m_s2 & m_s3);
    logic [2:0] clr = 3'b0;
    logic [2:0] set = {t2, t1, edg};
    if (acc) clr[f_win(p)] = 1'b1;
    if (f_hit()) clr[int'(skt_sel)] = 1'b1;
    m_fl = (m_fl & ~clr) | set;
    if (acc || gie_clr) m_gie = 0; else if (gie_set) m_gie = 1;
    if (en_we) m_en = en_wd;
    if (edge_we) m_edg = edge_wd;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
  endtask

  // One cycle: inputs already driven after a negedge.
  task automatic cycle();
    #1 check_outputs();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    idle();
    m_s1 = 0; m_s2 = 0; m_s3 = 0; m_gie = 0; m_fl = 0; m_en = 0; m_edg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, probe skip of all selects.
    chk("R1 valid", vvalid, 1'b0);
    for (int s = 0; s < 4; s++) begin
      skt_req = 1; skt_sel = 2'(s);
      #1 chk("R1 hit", hit, 1'b0);
    end
    idle();

    // R3, R5, R6: all three pending, drained in priority order.
    t1 = 1; t2 = 1; en_we = 1; en_wd = 4'b1101; gie_set = 1;
    cycle();
    idle();
    pin = 1; edge_we = 1; edge_wd = 4'b0100;  // R2 rising select
    cycle(); idle(); pin = 1;
    cycle(); cycle(); cycle();
    chk("R5 ext first addr", vaddr, 7'd0);
    for (int k = 0; k < 3; k++) begin
      pin = 1; ready = 1; gie_set = 0;
      cycle();
      chk("R7 gie cleared", vvalid, 1'b0);
      ready = 0; gie_set = 1;
      cycle();
      gie_set = 0;
      #1 if (k == 0) chk("R5 t1 next", vaddr, 7'd4);
      else if (k == 1) chk("R5 t2 last", vaddr, 7'd6);
    end

    // R7: clear beats set for the global enable.
    t1 = 1; gie_set = 1; gie_clr = 1;
    cycle(); idle(); pin = 1;
    chk("R7 clr wins", vvalid, 1'b0);

    // R10: request in the accept cycle survives.
    gie_set = 1; cycle(); idle(); pin = 1;
    ready = 1; t1 = 1; cycle(); idle(); pin = 1;
    gie_set = 1; cycle(); idle(); pin = 1;
    chk("R10 survives", vvalid, 1'b1);

    // R9: disabled source polled and cleared; R8 back-pressure random below.
    en_we = 1; en_wd = 4'b0000; cycle(); idle(); pin = 1;
    skt_req = 1; skt_sel = 2'd1;
    #1 chk("R9 hit first", hit, 1'b1);
    cycle();
    #1 chk("R9 cleared", hit, 1'b0);
    idle(); pin = 1;

    // Constrained random phase (R2, R4, R8, R9 and the rest).
    for (int n = 0; n < NCYC; n++) begin
      if ($urandom_range(0, 5) == 0) pin = ~pin;
      t1 = ($urandom_range(0, 9) == 0);
      t2 = ($urandom_range(0, 9) == 0);
      en_we = ($urandom_range(0, 39) == 0);
      en_wd = 4'($urandom);
      edge_we = ($urandom_range(0, 99) == 0);
      edge_wd = 4'($urandom);
      gie_set = ($urandom_range(0, 3) == 0);
      gie_clr = ($urandom_range(0, 29) == 0);
      ready = ($urandom_range(0, 2) == 0);
      skt_req = ($urandom_range(0, 2) == 0);
      skt_sel = 2'($urandom);
      cycle();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule